// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Sign Control

This block multiplies two 32-bit operands over several clock cycles and returns the 64-bit product as a high word and a low word. Each operation picks unsigned or two's-complement arithmetic. A caller presents both operands and the mode, pulses `start` while the unit is idle, and then waits for the one-cycle `done` pulse. The product stays on `hi`/`lo` until a later operation replaces it.

Inside, the operands become magnitudes and a result sign. One multiplier bit is handled per clock. When the bit is set, a shifted multiplicand is added into a 64-bit accumulator, and the carry from the low word passes into the high word. The loop stops once no set bit is left above the one just handled. A zero operand skips the loop entirely. A negative result is formed at the end by inverting both words and adding one to the low word, with the carry from that increment rippling into the high word.

Top module: `iter_mult`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, and `hi` and `lo` are both 0.
- R2: A `start` sampled at a rising edge while `busy` is 0, with both operands non-zero, makes `busy` read 1 after that edge.
- R3: If either operand is zero when `start` is accepted, `busy` stays 0, and after that same edge `done` is 1 with `hi` and `lo` both 0.
- R4: With `is_signed` = 0, the final `{hi, lo}` equals the unsigned 64-bit product of `op_a` and `op_b`. This holds for all-ones operands.
- R5: With `is_signed` = 1, the final `{hi, lo}` equals the two's-complement 64-bit product of the signed operands. This includes 0x80000000 as either or both operands.
- R6: For non-zero operands, the number of rising edges from the accepting edge to the edge that raises `done` equals one plus the index of the highest set bit of the magnitude of `op_a`. That count is never more than 32.
- R7: `done` is high for exactly one cycle per operation, and `busy` is 0 whenever `done` is 1.
- R8: `hi` and `lo` change only at the edge that raises `done`. They keep the previous result while busy and while idle.
- R9: A `start` sampled while `busy` is 1 has no effect. The running operation finishes with its original operands and mode, and it finishes at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 32 | Multiplier operand, scanned bit by bit |
| op_b | input | 32 | Multiplicand operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper word of the product |
| lo | output | 32 | Lower word of the product |

## Verification
The bench runs the multiplier with zero operands on either side, all-ones operands, and the most negative value in both modes. Unsigned and signed runs with these patterns give different products, so a fault in sign handling or in the final negation shows up. Multipliers of 1 and of 0x80000000 set the shortest and longest step counts, which tests the early stop. A random sweep in both modes checks the carry from the low word into the high word. Holding and ignored-start runs compare `hi`/`lo` against the previous result, cycle by cycle.

// File: rtl/mul_pkg.sv
package mul_pkg;
    parameter int OPW = 32;
    localparam int PW = 2 * OPW;
    localparam int CW = $clog2(OPW + 1);

    typedef logic [OPW-1:0] word_t;
    typedef logic [PW-1:0]  dword_t;

    typedef enum logic {ST_IDLE, ST_RUN} mul_state_e;

    typedef struct packed {
        word_t  mplier;
        dword_t mcand;
        logic   neg;
        logic   zero;
    } prep_t;

    typedef struct packed {
        dword_t acc;
        dword_t mcand;
        word_t  mplier;
        logic   last;
    } step_t;

    function automatic word_t magnitude(input word_t v, input logic take_neg);
        return take_neg ? (~v + word_t'(1)) : v;
    endfunction
endpackage

// File: rtl/mul_prep.sv
module mul_prep
    import mul_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  sgn,
    output prep_t prep
);
    logic a_neg, b_neg;
    word_t b_mag;

    always_comb begin
        a_neg       = sgn & a[OPW-1];
        b_neg       = sgn & b[OPW-1];
        b_mag       = magnitude(b, b_neg);
        prep.mplier = magnitude(a, a_neg);
        prep.mcand  = {word_t'(0), b_mag};
        prep.neg    = a_neg ^ b_neg;
        prep.zero   = (a == '0) || (b == '0);
    end
endmodule

// File: rtl/mul_step.sv
module mul_step
    import mul_pkg::*;
(
    input  dword_t acc,
    input  dword_t mcand,
    input  word_t  mplier,
    output step_t  nxt
);
    logic [OPW:0]  lo_sum;
    word_t         hi_sum;
    dword_t        added;

    always_comb begin
        lo_sum = {1'b0, acc[OPW-1:0]} + {1'b0, mcand[OPW-1:0]};
        hi_sum = acc[PW-1:OPW] + mcand[PW-1:OPW] + word_t'(lo_sum[OPW]);
        added  = {hi_sum, lo_sum[OPW-1:0]};
        nxt.acc    = mplier[0] ? added : acc;
        nxt.mcand  = {mcand[PW-2:0], 1'b0};
        nxt.mplier = {1'b0, mplier[OPW-1:1]};
        nxt.last   = (mplier[OPW-1:1] == '0);
    end
endmodule

// File: rtl/mul_fix.sv
module mul_fix
    import mul_pkg::*;
(
    input  dword_t raw,
    input  logic   neg,
    output dword_t res
);
    word_t inv_hi, inv_lo, lo_inc;

    always_comb begin
        inv_hi = ~raw[PW-1:OPW];
        inv_lo = ~raw[OPW-1:0];
        lo_inc = inv_lo + word_t'(1);
        if (neg)
            res = {inv_hi + word_t'(lo_inc == '0), lo_inc};
        else
            res = raw;
    end
endmodule

// File: rtl/iter_mult.sv
module iter_mult
    import mul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_signed,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic             busy,
    output logic             done,
    output logic [OPW-1:0]   hi,
    output logic [OPW-1:0]   lo
);
    mul_state_e      state;
    dword_t          acc, mcand;
    word_t           mplier;
    logic            neg;
    logic [CW-1:0]   step_cnt;
    prep_t           prep;
    step_t           nxt;
    dword_t          fixed;

    mul_prep u_prep (.a(op_a), .b(op_b), .sgn(is_signed), .prep(prep));
    mul_step u_step (.acc(acc), .mcand(mcand), .mplier(mplier), .nxt(nxt));
    mul_fix  u_fix  (.raw(nxt.acc), .neg(neg), .res(fixed));

    assign busy = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            acc      <= '0;
            mcand    <= '0;
            mplier   <= '0;
            neg      <= 1'b0;
            step_cnt <= '0;
            hi       <= '0;
            lo       <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (prep.zero) begin
                            hi   <= '0;
                            lo   <= '0;
                            done <= 1'b1;
                        end else begin
                            acc      <= '0;
                            mcand    <= prep.mcand;
                            mplier   <= prep.mplier;
                            neg      <= prep.neg;
                            step_cnt <= '0;
                            state    <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc      <= nxt.acc;
                    mcand    <= nxt.mcand;
                    mplier   <= nxt.mplier;
                    step_cnt <= step_cnt + CW'(1);
                    if (nxt.last) begin
                        hi    <= fixed[PW-1:OPW];
                        lo    <= fixed[OPW-1:0];
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    zero_short_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op_a == '0 || op_b == '0))
            |=> (done && !busy && hi == '0 && lo == '0));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op_a != '0 && op_b != '0) |=> busy);

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_cnt < CW'(OPW)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({hi, lo}));

    // R9
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !nxt.last) |=> busy);
endmodule

// File: tb/sim_iter_mult.sv
module sim_iter_mult;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_signed;
    logic [31:0] op_a, op_b;
    logic        busy, done;
    logic [31:0] hi, lo;

    int n_checks = 0;
    int n_fail   = 0;

    iter_mult u0 (.clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
                  .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
                  .hi(hi), .lo(lo));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                             input bit s);
        logic [63:0] ea, eb;
        ea = s ? {{32{a[31]}}, a} : {32'b0, a};
        eb = s ? {{32{b[31]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    function automatic int ref_steps(input logic [31:0] a, input logic [31:0] b,
                                     input bit s);
        logic [31:0] m;
        int top;
        if (a == 0 || b == 0) return 0;
        m = (s && a[31]) ? (~a + 32'd1) : a;
        top = 0;
        for (int i = 0; i < 32; i++) if (m[i]) top = i;
        return top + 1;
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s);
        @(negedge clk);
        op_a = a; op_b = b; is_signed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int steps);
        steps = 0;
        while (!done && steps < 40) begin
            @(negedge clk);
            steps++;
        end
    endtask

    task automatic run_check(input logic [31:0] a, input logic [31:0] b, input bit s,
                             input string req);
        int steps;
        logic [63:0] exp;
        exp = ref_prod(a, b, s);
        issue(a, b, s);
        wait_done(steps);
        chk({hi, lo} == exp, req, {hi, lo}, exp);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {62'b0, busy, done}, 64'd0);
        chk({hi, lo} == 64'd0, "R1 hi/lo", {hi, lo}, 64'd0);
    endtask

    task automatic t_zero;
        int steps;
        issue(32'd0, 32'd5, 1'b1);
        chk(done && !busy, "R3 done after zero a", {62'b0, busy, done}, 64'd1);
        chk({hi, lo} == 64'd0, "R3 zero a product", {hi, lo}, 64'd0);
        issue(32'h8000_0000, 32'd0, 1'b0);
        wait_done(steps);
        chk(steps == 0, "R3 zero b latency", 64'(steps), 64'd0);
        chk({hi, lo} == 64'd0, "R3 zero b product", {hi, lo}, 64'd0);
    endtask

    task automatic t_unsigned;
        run_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 all ones");
        run_check(32'h8000_0000, 32'd2, 1'b0, "R4 msb times two");
        run_check(32'h0001_0000, 32'h0001_0000, 1'b0, "R4 carry into hi");
    endtask

    task automatic t_signed;
        run_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 minus one squared");
        run_check(32'h8000_0000, 32'h8000_0000, 1'b1, "R5 most negative squared");
        run_check(32'h8000_0000, 32'd1, 1'b1, "R5 most negative times one");
        run_check(32'hFFFF_FFFD, 32'd7, 1'b1, "R5 minus three times seven");
        run_check(32'd9, 32'h8000_0000, 1'b1, "R5 most negative as b");
    endtask

    task automatic t_latency;
        int steps;
        issue(32'd1, 32'd3, 1'b0);
        chk(busy == 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
        wait_done(steps);
        chk(steps == 1, "R6 latency a=1", 64'(steps), 64'd1);
        chk(!busy, "R7 busy low with done", {63'b0, busy}, 64'd0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", {63'b0, done}, 64'd0);
        issue(32'h8000_0000, 32'd3, 1'b0);
        wait_done(steps);
        chk(steps == 32, "R6 latency a=msb unsigned", 64'(steps), 64'd32);
        issue(32'hFFFF_FFFF, 32'd3, 1'b1);
        wait_done(steps);
        chk(steps == 1, "R6 latency a=-1 signed", 64'(steps), 64'd1);
        issue(32'h0000_0100, 32'd3, 1'b0);
        wait_done(steps);
        chk(steps == ref_steps(32'h100, 32'd3, 1'b0), "R6 latency a=0x100",
            64'(steps), 64'(ref_steps(32'h100, 32'd3, 1'b0)));
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        bit ok;
        int steps;
        run_check(32'd6, 32'd7, 1'b0, "R4 small product");
        prev = {hi, lo};
        ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if ({hi, lo} != prev) ok = 1'b0;
        end
        chk(ok, "R8 hold while idle", {hi, lo}, prev);
        issue(32'h4000_0000, 32'd5, 1'b0);
        ok = 1'b1;
        steps = 0;
        while (!done && steps < 40) begin
            if ({hi, lo} != prev) ok = 1'b0;
            @(negedge clk);
            steps++;
        end
        chk(ok, "R8 hold while busy", {hi, lo}, prev);
    endtask

    task automatic t_busy_start;
        int steps;
        issue(32'h8000_0000, 32'd3, 1'b0);
        op_a = 32'd5; op_b = 32'hFFFF_FFFF; is_signed = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(steps);
        chk({hi, lo} == 64'h1_8000_0000, "R9 start while busy ignored", {hi, lo},
            64'h1_8000_0000);
        chk(steps == 31, "R9 finish time unchanged", 64'(steps), 64'd31);
    endtask

    task automatic t_random;
        logic [31:0] a, b;
        for (int i = 0; i < 40; i++) begin
            a = $urandom();
            b = $urandom();
            run_check(a, b, i[0], i[0] ? "R5 random signed" : "R4 random unsigned");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; is_signed = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero();
        t_unsigned();
        t_signed();
        t_latency();
        t_hold();
        t_busy_start();
        t_random();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule